// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers level-sensitive interrupt lines from up to 32 on-chip sources. A rising line sets its bit in a pending register. If that source is also enabled in the mask register, the block tells the processor by issuing one 32-bit bus write on a master port. No dedicated interrupt wire is used. The target address and the interrupt number both come from one software-programmed vector register: the address is the register with its five low bits cleared, and the data is those five low bits.

Software reaches the block through a small 32-bit register slave port with byte strobes. Through it, software can:
- read the live source levels, the pending bits and the mask;
- clear the pending register by reading it or by writing it;
- program the vector register;
- set a bus-error bit in the control register, which stops delivery;
- fire a transfer-of-control strobe from the control register.

Only one delivery write is outstanding at a time. Source edges that arrive while a write is unacknowledged merge into a single follow-up write.

Top module: `irq_msg_agg`

## Requirements
- R1: The request register (word offset 0x00) reads back the current source levels, zero-extended to 32 bits; writes to it change nothing and get an OK response.
- R2: A read of the pending register (offset 0x08) returns its value and clears all its bits at the same clock edge.
- R3: Any write to the pending register clears it, whatever the data and strobes.
- R4: A low-to-high change on source n sets pending bit n. If a clear of the pending register falls in the same cycle, the new edge wins and its bit stays set.
- R5: The mask register (offset 0x04) stores only bits 5, 7, 8, 9, 13, 14 and 16 to 21; other written bits read back as zero. A mask write whose merged value has any other bit set pulses `mask_err` for one cycle, together with the response. The exception is the value 0xFFFFFFFF, which raises no flag.
- R6: An edge on an enabled source starts a write on the master port in the cycle after the edge is sampled. The write has address = vector & 0xFFFFFFE0 and data = vector & 0x1F. Valid, address and data hold steady until `msg_ready` is high. An edge on a masked-off source starts no write.
- R7: A new write starts only after the previous one is acknowledged. Any number of enabled edges seen while a write is outstanding produce exactly one further write.
- R8: While control bit 8 (bus error) is set, no write starts, and deliveries requested meanwhile are dropped. A control read returns only bit 8.
- R9: Writing control bit 1 as one (byte lane 0) drives `toc_pulse` high for exactly the cycle after the write.
- R10: Byte strobes follow big-endian lane order. `cfg_strb[3]` carries bits 31:24, the byte at the lowest address; `cfg_strb[0]` carries bits 7:0. Unstrobed bytes of the mask, control and vector registers keep their value.
- R11: Accesses to unmapped offsets get `cfg_rsp_err` high with read data zero and change no state.
- R12: After reset the mask, pending and control registers are zero, the vector register holds `VEC_RESET` (default 0x00001003), `msg_valid` is low, and every access returns a response one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NSRC | Level interrupt lines from the sources |
| cfg_valid | input | 1 | Register access presented this cycle |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | ADDR_W-2 | Word address of the register (byte offset bits 7:2) |
| cfg_strb | input | 4 | Byte strobes, bit 3 = lowest-address byte (bits 31:24) |
| cfg_wdata | input | 32 | Write data |
| cfg_rsp_valid | output | 1 | Response strobe, one cycle after the access |
| cfg_rdata | output | 32 | Read data |
| cfg_rsp_err | output | 1 | Decode error for an unmapped offset |
| msg_valid | output | 1 | Delivery write request |
| msg_addr | output | 32 | Delivery write address |
| msg_data | output | 32 | Delivery write data (interrupt number) |
| msg_ready | input | 1 | Delivery write accepted |
| mask_err | output | 1 | One-cycle flag for an illegal mask write |
| toc_pulse | output | 1 | One-cycle transfer-of-control strobe |

## Verification
A corrupted pending bit shows up at the next read of the pending register, one cycle after that read is presented. The read also shows whether the clear happened, because a second read must return zero. A wrong mask or delivery state shows on the master port one cycle after the source edge: either a write that should not appear, a write that is missing, or one with the wrong address or data. A broken outstanding-write tracker shows as a wrong number of writes once `msg_ready` is raised again, so the bench matches every write against the queue of expected writes.

// File: rtl/irq_msg_pkg.sv
package irq_msg_pkg;

   typedef enum logic [2:0] {
      SEL_REQ,
      SEL_MASK,
      SEL_PEND,
      SEL_CTRL,
      SEL_VEC,
      SEL_NONE
   } reg_sel_e;

   localparam logic [31:0] OFF_REQ  = 32'h0000_0000;
   localparam logic [31:0] OFF_MASK = 32'h0000_0004;
   localparam logic [31:0] OFF_PEND = 32'h0000_0008;
   localparam logic [31:0] OFF_CTRL = 32'h0000_000C;
   localparam logic [31:0] OFF_VEC  = 32'h0000_0010;

   localparam int CTRL_BUSERR_BIT = 8;
   localparam int CTRL_TOC_BIT    = 1;
   localparam int NUM_W           = 5;

   function automatic reg_sel_e decode_off(input logic [31:0] off);
      reg_sel_e s;
      case (off)
         OFF_REQ:  s = SEL_REQ;
         OFF_MASK: s = SEL_MASK;
         OFF_PEND: s = SEL_PEND;
         OFF_CTRL: s = SEL_CTRL;
         OFF_VEC:  s = SEL_VEC;
         default:  s = SEL_NONE;
      endcase
      return s;
   endfunction

   // strobe bit 3 is the lowest-address byte (big-endian), i.e. bits 31:24
   function automatic logic [31:0] lane_merge(input logic [31:0] cur,
                                              input logic [31:0] wr,
                                              input logic [3:0]  strb);
      logic [31:0] res;
      res = cur;
      for (int b = 0; b < 4; b++) begin
         if (strb[b]) res[8*b +: 8] = wr[8*b +: 8];
      end
      return res;
   endfunction

endpackage

// File: rtl/irq_msg_pend.sv
module irq_msg_pend #(
   parameter int NSRC = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] src_irq,
   input  logic [NSRC-1:0] mask_q,
   input  logic            pend_clr,
   output logic [NSRC-1:0] pend_q,
   output logic            hit
);

   logic [NSRC-1:0] src_q;
   logic [NSRC-1:0] rise;

   always_ff @(posedge clk) begin
      if (!rst_n) src_q <= '0;
      else        src_q <= src_irq;
   end

   assign rise = src_irq & ~src_q;
   assign hit  = |(rise & mask_q);

   for (genvar i = 0; i < NSRC; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)        pend_q[i] <= 1'b0;
         else if (rise[i])  pend_q[i] <= 1'b1;
         else if (pend_clr) pend_q[i] <= 1'b0;
      end

      assert_edge_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (src_irq[i] && !src_q[i]) |=> pend_q[i]);
   end

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_clr && (rise == '0)) |=> (pend_q == '0));

endmodule

// File: rtl/irq_msg_regs.sv
module irq_msg_regs
   import irq_msg_pkg::*;
#(
   parameter int          NSRC      = 32,
   parameter int          ADDR_W    = 8,
   parameter logic [31:0] ENABLE_OK = 32'h003F_63A0,
   parameter logic [31:0] VEC_RESET = 32'h0000_1003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_valid,
   input  logic              cfg_write,
   input  logic [ADDR_W-1:2] cfg_addr,
   input  logic [3:0]        cfg_strb,
   input  logic [31:0]       cfg_wdata,
   input  logic [31:0]       req_vec,
   input  logic [31:0]       pend_vec,
   output logic              cfg_rsp_valid,
   output logic [31:0]       cfg_rdata,
   output logic              cfg_rsp_err,
   output logic              pend_clr,
   output logic [NSRC-1:0]   mask_q,
   output logic              bus_err,
   output logic [31:0]       vec_q,
   output logic              mask_err,
   output logic              toc_pulse
);

   reg_sel_e    sel;
   logic        wr_en;
   logic [31:0] mask_ext;
   logic [31:0] mask_merged;
   logic        mask_bad;
   logic [31:0] rd_mux;

   assign sel         = decode_off(32'({cfg_addr, 2'b00}));
   assign wr_en       = cfg_valid & cfg_write;
   assign mask_ext    = 32'(mask_q);
   assign mask_merged = lane_merge(mask_ext, cfg_wdata, cfg_strb);
   assign mask_bad    = ((mask_merged & ~ENABLE_OK) != '0) && (mask_merged != '1);
   assign pend_clr    = cfg_valid && (sel == SEL_PEND);

   always_comb begin
      case (sel)
         SEL_REQ:  rd_mux = req_vec;
         SEL_MASK: rd_mux = mask_ext;
         SEL_PEND: rd_mux = pend_vec;
         SEL_CTRL: rd_mux = 32'(bus_err) << CTRL_BUSERR_BIT;
         SEL_VEC:  rd_mux = vec_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q    <= '0;
         bus_err   <= 1'b0;
         vec_q     <= VEC_RESET;
         mask_err  <= 1'b0;
         toc_pulse <= 1'b0;
      end else begin
         mask_err  <= wr_en && (sel == SEL_MASK) && mask_bad;
         toc_pulse <= wr_en && (sel == SEL_CTRL) && cfg_strb[0] && cfg_wdata[CTRL_TOC_BIT];
         if (wr_en && (sel == SEL_MASK))
            mask_q <= mask_merged[NSRC-1:0] & ENABLE_OK[NSRC-1:0];
         if (wr_en && (sel == SEL_CTRL) && cfg_strb[1])
            bus_err <= cfg_wdata[CTRL_BUSERR_BIT];
         if (wr_en && (sel == SEL_VEC))
            vec_q <= lane_merge(vec_q, cfg_wdata, cfg_strb);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_rsp_valid <= 1'b0;
         cfg_rdata     <= '0;
         cfg_rsp_err   <= 1'b0;
      end else begin
         cfg_rsp_valid <= cfg_valid;
         cfg_rsp_err   <= cfg_valid && (sel == SEL_NONE);
         cfg_rdata     <= (cfg_valid && !cfg_write) ? rd_mux : '0;
      end
   end

   assert_mask_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_ext & ~ENABLE_OK) == '0);

   assert_decode_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && (sel == SEL_NONE)) |=> (cfg_rsp_err && (cfg_rdata == '0)));

   assert_ctrl_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_valid && !cfg_write && (sel == SEL_CTRL))
         |=> ((cfg_rdata & ~(32'h1 << CTRL_BUSERR_BIT)) == '0));

   assert_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> cfg_rsp_valid);

endmodule

// File: rtl/irq_msg_tx.sv
module irq_msg_tx
   import irq_msg_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hit,
   input  logic        bus_err,
   input  logic [31:0] vec_q,
   input  logic        msg_ready,
   output logic        msg_valid,
   output logic [31:0] msg_addr,
   output logic [31:0] msg_data
);

   logic want_q;
   logic launch;

   assign launch = (hit | want_q) & ~bus_err & ~msg_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         want_q    <= 1'b0;
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else begin
         want_q <= (hit | want_q) & ~bus_err & ~launch;
         if (launch) begin
            msg_valid <= 1'b1;
            msg_addr  <= {vec_q[31:NUM_W], {NUM_W{1'b0}}};
            msg_data  <= {{(32-NUM_W){1'b0}}, vec_q[NUM_W-1:0]};
         end else if (msg_ready) begin
            msg_valid <= 1'b0;
         end
      end
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

   assert_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> (msg_addr[NUM_W-1:0] == '0));

   assert_suppress_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err && !msg_valid) |=> !msg_valid);

   assert_one_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready) |=> !msg_valid);

endmodule

// File: rtl/irq_msg_agg.sv
module irq_msg_agg
   import irq_msg_pkg::*;
#(
   parameter int          NSRC      = 32,
   parameter int          ADDR_W    = 8,
   parameter logic [31:0] ENABLE_OK = 32'h003F_63A0,
   parameter logic [31:0] VEC_RESET = 32'h0000_1003
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   src_irq,
   input  logic              cfg_valid,
   input  logic              cfg_write,
   input  logic [ADDR_W-1:2] cfg_addr,
   input  logic [3:0]        cfg_strb,
   input  logic [31:0]       cfg_wdata,
   output logic              cfg_rsp_valid,
   output logic [31:0]       cfg_rdata,
   output logic              cfg_rsp_err,
   output logic              msg_valid,
   output logic [31:0]       msg_addr,
   output logic [31:0]       msg_data,
   input  logic              msg_ready,
   output logic              mask_err,
   output logic              toc_pulse
);

   if (NSRC < 1 || NSRC > 32) begin : g_bad_nsrc
      $error("irq_msg_agg: NSRC must lie in 1..32");
   end
   if (ADDR_W < 5) begin : g_bad_addr
      $error("irq_msg_agg: ADDR_W too narrow for the register map");
   end

   logic [NSRC-1:0] mask_q;
   logic [NSRC-1:0] pend_q;
   logic            pend_clr;
   logic            hit;
   logic            bus_err;
   logic [31:0]     vec_q;

   irq_msg_regs #(
      .NSRC(NSRC), .ADDR_W(ADDR_W), .ENABLE_OK(ENABLE_OK), .VEC_RESET(VEC_RESET)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
      .cfg_strb(cfg_strb), .cfg_wdata(cfg_wdata),
      .req_vec(32'(src_irq)), .pend_vec(32'(pend_q)),
      .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata), .cfg_rsp_err(cfg_rsp_err),
      .pend_clr(pend_clr), .mask_q(mask_q), .bus_err(bus_err), .vec_q(vec_q),
      .mask_err(mask_err), .toc_pulse(toc_pulse)
   );

   irq_msg_pend #(.NSRC(NSRC)) u_pend (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .mask_q(mask_q),
      .pend_clr(pend_clr), .pend_q(pend_q), .hit(hit)
   );

   irq_msg_tx u_tx (
      .clk(clk), .rst_n(rst_n), .hit(hit), .bus_err(bus_err), .vec_q(vec_q),
      .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_addr(msg_addr),
      .msg_data(msg_data)
   );

endmodule

// File: tb/tb_irq_msg_agg.sv
module tb_irq_msg_agg;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_irq = '0;
   logic        cfg_valid = 1'b0;
   logic        cfg_write = 1'b0;
   logic [7:2]  cfg_addr = '0;
   logic [3:0]  cfg_strb = '0;
   logic [31:0] cfg_wdata = '0;
   logic        cfg_rsp_valid;
   logic [31:0] cfg_rdata;
   logic        cfg_rsp_err;
   logic        msg_valid;
   logic [31:0] msg_addr;
   logic [31:0] msg_data;
   logic        msg_ready = 1'b1;
   logic        mask_err;
   logic        toc_pulse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;
   logic [63:0] exp_q[$];
   logic last_toc, last_merr, last_rv;

   always #5 clk = ~clk;

   irq_msg_agg dut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
      .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
      .cfg_strb(cfg_strb), .cfg_wdata(cfg_wdata),
      .cfg_rsp_valid(cfg_rsp_valid), .cfg_rdata(cfg_rdata), .cfg_rsp_err(cfg_rsp_err),
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .msg_ready(msg_ready), .mask_err(mask_err), .toc_pulse(toc_pulse)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge with the response
   task automatic acc(input logic w, input logic [7:0] off, input logic [3:0] strb,
                      input logic [31:0] wd, output logic [31:0] rd, output logic er);
      cfg_valid = 1'b1; cfg_write = w; cfg_addr = off[7:2]; cfg_strb = strb; cfg_wdata = wd;
      @(negedge clk);
      cfg_valid = 1'b0; cfg_write = 1'b0;
      rd = cfg_rdata; er = cfg_rsp_err;
      last_toc = toc_pulse; last_merr = mask_err; last_rv = cfg_rsp_valid;
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   // scoreboard monitor: compares each accepted delivery write with the queue
   always @(negedge clk) begin
      #1;
      if (rst_n && msg_valid && msg_ready) begin
         if (exp_q.size() == 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R7: actual unexpected write %h/%h expected none", msg_addr, msg_data);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            chk("R6 addr", msg_addr, e[63:32]);
            chk("R6 data", msg_data, e[31:0]);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic er;
      wait_cyc(3);
      rst_n = 1'b1;
      @(negedge clk);

      // R12 reset state
      chk("R12 msg_valid", 32'(msg_valid), 0);
      acc(0, 8'h04, 4'hF, 0, rd, er); chk("R12 mask", rd, 0); chk("R12 rsp_valid", 32'(last_rv), 1);
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R12 pend", rd, 0);
      acc(0, 8'h0C, 4'hF, 0, rd, er); chk("R12 ctrl", rd, 0);
      acc(0, 8'h10, 4'hF, 0, rd, er); chk("R12 vec", rd, 32'h0000_1003);

      // R1 request register is live and read-only
      src_irq = 32'h0000_0300;
      @(negedge clk);
      acc(0, 8'h00, 4'hF, 0, rd, er); chk("R1 read", rd, 32'h0000_0300);
      acc(1, 8'h00, 4'hF, 32'hFFFF_FFFF, rd, er); chk("R1 write resp", 32'(er), 0);
      acc(0, 8'h00, 4'hF, 0, rd, er); chk("R1 after write", rd, 32'h0000_0300);

      // R2 clear on read
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R2 first read", rd, 32'h0000_0300);
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R2 second read", rd, 0);

      // R3 clear on write, any data
      src_irq[13] = 1'b1;
      @(negedge clk);
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R3 pend set", rd, 32'h0000_2000);
      src_irq[14] = 1'b1;
      @(negedge clk);
      acc(1, 8'h08, 4'b0001, 32'h0, rd, er);
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R3 after write", rd, 0);

      // R4 edge wins over a concurrent clear (read, then write)
      src_irq[16] = 1'b1;
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R4 read old", rd, 0);
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R4 edge kept on read clear", rd, 32'h0001_0000);
      src_irq[17] = 1'b1;
      acc(1, 8'h08, 4'hF, 32'hFFFF_FFFF, rd, er);
      acc(0, 8'h08, 4'hF, 0, rd, er); chk("R4 edge kept on write clear", rd, 32'h0002_0000);

      // R5 mask legality
      acc(1, 8'h04, 4'hF, 32'h0000_0001, rd, er); chk("R5 err flag", 32'(last_merr), 1);
      acc(0, 8'h04, 4'hF, 0, rd, er); chk("R5 illegal not stored", rd, 0);
      chk("R5 flag one cycle", 32'(last_merr), 0);
      acc(1, 8'h04, 4'hF, 32'h0000_0020, rd, er); chk("R5 legal no flag", 32'(last_merr), 0);
      acc(0, 8'h04, 4'hF, 0, rd, er); chk("R5 legal stored", rd, 32'h0000_0020);

      // R10 big-endian byte lanes on the vector register
      acc(1, 8'h10, 4'b1000, 32'hAB00_0000, rd, er);
      acc(0, 8'h10, 4'hF, 0, rd, er); chk("R10 top lane", rd, 32'hAB00_1003);
      acc(1, 8'h10, 4'b0001, 32'h5555_55E7, rd, er);
      acc(0, 8'h10, 4'hF, 0, rd, er); chk("R10 low lane", rd, 32'hAB00_10E7);

      // R5 all-ones accepted
      acc(1, 8'h04, 4'hF, 32'hFFFF_FFFF, rd, er); chk("R5 all-ones no flag", 32'(last_merr), 0);
      acc(0, 8'h04, 4'hF, 0, rd, er); chk("R5 all-ones stored", rd, 32'h003F_63A0);

      // R6 delivery of an enabled edge
      src_irq[5] = 1'b1;
      exp_q.push_back({32'hAB00_10E0, 32'h0000_0007});
      wait_cyc(5);
      // R6 masked-off source delivers nothing
      src_irq[0] = 1'b1;
      wait_cyc(4);
      chk("R6 masked-off no write", 32'(msg_valid), 0);

      // R7 one outstanding; edges during stall coalesce into one more write
      msg_ready = 1'b0;
      src_irq[7] = 1'b1;
      exp_q.push_back({32'hAB00_10E0, 32'h0000_0007});
      wait_cyc(3);
      chk("R6 held while stalled", 32'(msg_valid), 1);
      chk("R6 held addr", msg_addr, 32'hAB00_10E0);
      src_irq[19] = 1'b1;
      exp_q.push_back({32'hAB00_10E0, 32'h0000_0007});
      @(negedge clk);
      src_irq[20] = 1'b1;
      wait_cyc(3);
      chk("R7 still one pending", 32'(msg_valid), 1);
      msg_ready = 1'b1;
      wait_cyc(8);
      chk("R7 queue drained", 32'(exp_q.size()), 0);

      // R8 bus error suppresses; R9 transfer-of-control pulse
      acc(1, 8'h0C, 4'hF, 32'h0000_0102, rd, er); chk("R9 toc pulse", 32'(last_toc), 1);
      @(negedge clk); chk("R9 toc one cycle", 32'(toc_pulse), 0);
      acc(0, 8'h0C, 4'hF, 0, rd, er); chk("R8 ctrl reads bit 8 only", rd, 32'h0000_0100);
      src_irq[21] = 1'b1;
      wait_cyc(4);
      chk("R8 suppressed", 32'(msg_valid), 0);
      acc(1, 8'h0C, 4'b0010, 32'h0000_0000, rd, er);
      wait_cyc(4);
      chk("R8 dropped after clear", 32'(msg_valid), 0);
      acc(0, 8'h0C, 4'hF, 0, rd, er); chk("R8 ctrl cleared", rd, 0);

      // R11 unmapped offsets
      acc(0, 8'h14, 4'hF, 0, rd, er); chk("R11 read err", 32'(er), 1); chk("R11 read data", rd, 0);
      acc(1, 8'h40, 4'hF, 32'hFFFF_FFFF, rd, er); chk("R11 write err", 32'(er), 1);
      acc(0, 8'h10, 4'hF, 0, rd, er); chk("R11 no side effect", rd, 32'hAB00_10E7);

      wait_cyc(4);
      chk("R7 final queue empty", 32'(exp_q.size()), 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule